// File: doc/BRIEF.md
# Page-Mode Word Memory Model

This block is a clock-synchronous behavioural model of a word-wide parallel memory with page access. Asynchronous active-low strobes (chip enable, write enable, output enable, two byte-lane enables and a sleep request) are brought into the clock domain together with the address and the write data. The model then runs the memory's access protocol in whole clock cycles. The word address is split into a row part and a two-bit column part. The row is captured when a cycle opens. Column-only changes inside an open row are served with the short page latency. A row change, or the release of chip enable, costs a precharge interval.

Writes come in two styles. In the first, write enable is already low when chip enable falls. In the second, write enable falls later inside an open cycle. Both commit at the first rising edge of either strobe, and only the byte lanes whose enables are low are written. The bus is enabled per byte lane, and only once the access has completed. A sleep request silences the whole interface, and after it is released new cycles are refused for a programmable wake interval. The default build uses a 10-bit address (1024 words) to keep elaboration light. Setting `ADDR_W` to 17 gives the full 128K-word organisation.

Top module: `nvm_page_mem`

## Requirements
- R1: A word written at an address is returned by a later read of the same address. The row is `addr[ADDR_W-1:2]` and the column is `addr[1:0]`.
- R2: A falling `ce_n` while the synchronised `we_n` is high opens a read. `dq_oe` stays `2'b00` until `T_ACC` cycles have elapsed, and the word is then driven.
- R3: While `ce_n` stays low, a change of `addr[1:0]` alone yields the new word after `T_PAGE` cycles, well before a full access time.
- R4: While `ce_n` stays low, a change of the row bits first waits `T_PC` cycles and then `T_ACC` cycles. The bus is not driven in between, and the new row's word follows.
- R5: `dq_oe[1]` (bits 15..8) needs `ub_n` low, and `dq_oe[0]` (bits 7..0) needs `lb_n` low. Both lanes also need `oe_n` low and `we_n` high.
- R6: A rise of `ce_n` starts a `T_PC`-cycle precharge. A fall of `ce_n` during that precharge opens no cycle and produces no drive.
- R7: A cycle opened with `we_n` low commits at the rise of `ce_n`. A write started by a fall of `we_n` in an open cycle commits at the rise of `we_n`. Neither kind of write drives the bus.
- R8: Inside one open row, each further `we_n` pulse with a new column writes that column without toggling `ce_n`.
- R9: A committed write changes only the bytes whose enables are low: `ub_n` controls bits 15..8 and `lb_n` controls bits 7..0.
- R10: A write whose closing edge arrives before its access count has expired raises `viol` for one cycle and leaves memory unchanged.
- R11: With `sleep_n` low, the bus is released and every other input is ignored. After release, a `ce_n` fall within `T_ZZ` cycles opens no cycle.
- R12: After reset, the bus is not driven and `viol` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte-lane enable, active low |
| lb_n | input | 1 | Lower byte-lane enable, active low |
| sleep_n | input | 1 | Sleep request, active low |
| addr | input | ADDR_W | Word address: row bits above, column in bits 1..0 |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus |
| dq_oe | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |
| viol | output | 1 | One-cycle pulse on a write ended too early |

## Verification
The bound checker watches the bus gating on every cycle. Neither lane may drive unless, one cycle earlier, output enable, write enable, its byte enable and sleep all allowed it. It also checks that commits happen only on a rising strobe edge, that a flagged violation never coincides with a commit, that sleep releases the bus and blocks writes, and that precharge never leads directly into an access. The latency contrasts need the bench's scenarios: page access against full access, a row change that waits through precharge, refusal during precharge and wake, byte-masked contents and page writes across four columns. These depend on stored data and on timing across several strobes.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int DQ_W  = 16;
    localparam int LANES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_ROWPC,
        ST_PRECH,
        ST_SLEEP,
        ST_WAKE
    } nvm_state_e;
endpackage

// File: rtl/nvm_sync.sv
module nvm_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/nvm_array.sv
module nvm_array
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      waddr,
    input  logic [DQ_W-1:0]        wdata,
    input  logic [LANES-1:0]       wbe,
    input  logic [ADDR_W-1:0]      raddr,
    output logic [DQ_W-1:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wbe[g]) begin
                mem[waddr] <= wdata[g*8 +: 8];
            end
        end

        assign rdata[g*8 +: 8] = mem[raddr];
    end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int T_ACC  = 8,
    parameter int T_PAGE = 3,
    parameter int T_PC   = 4,
    parameter int T_ZZ   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_ce,
    input  logic               s_we,
    input  logic               s_oe,
    input  logic               s_ub,
    input  logic               s_lb,
    input  logic               s_sleep,
    input  logic [ADDR_W-1:0]  s_addr,
    input  logic [DQ_W-1:0]    s_dq,
    input  logic [DQ_W-1:0]    rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               wr_en,
    output logic [DQ_W-1:0]    wdata,
    output logic [LANES-1:0]   wbe,
    output logic [DQ_W-1:0]    dq_out,
    output logic [LANES-1:0]   dq_oe,
    output logic               viol,
    output nvm_state_e         state
);
    localparam int ROW_W = ADDR_W - 2;
    localparam int CMAX  = (T_ACC > T_PC) ? ((T_ACC > T_ZZ) ? T_ACC : T_ZZ)
                                          : ((T_PC > T_ZZ) ? T_PC : T_ZZ);
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam logic [CNT_W-1:0] C_ACC  = CNT_W'(T_ACC);
    localparam logic [CNT_W-1:0] C_PAGE = CNT_W'(T_PAGE);
    localparam logic [CNT_W-1:0] C_PC   = CNT_W'(T_PC);
    localparam logic [CNT_W-1:0] C_ZZ   = CNT_W'(T_ZZ);

    typedef struct packed {
        nvm_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic [1:0]        col;
        logic              wr;
        logic              p_ce;
        logic              p_we;
        logic [DQ_W-1:0]   dout;
        logic [LANES-1:0]  oe;
        logic              viol;
    } ctrl_t;

    ctrl_t d_d, d_q;

    logic             ce_fall, ce_rise, we_fall, we_rise, cnt_zero, data_ok;
    logic [ROW_W-1:0] row_in;
    logic [1:0]       col_in;

    always_comb begin
        ce_fall  = d_q.p_ce && !s_ce;
        ce_rise  = !d_q.p_ce && s_ce;
        we_fall  = d_q.p_we && !s_we;
        we_rise  = !d_q.p_we && s_we;
        cnt_zero = (d_q.cnt == '0);
        row_in   = s_addr[ADDR_W-1:2];
        col_in   = s_addr[1:0];

        d_d      = d_q;
        d_d.p_ce = s_ce;
        d_d.p_we = s_we;
        d_d.viol = 1'b0;
        wr_en    = 1'b0;

        if (!s_sleep) begin
            d_d.st = ST_SLEEP;
            d_d.wr = 1'b0;
        end else begin
            unique case (d_q.st)
                ST_IDLE: begin
                    if (ce_fall) begin
                        d_d.st  = ST_ACTIVE;
                        d_d.row = row_in;
                        d_d.col = col_in;
                        d_d.cnt = C_ACC;
                        d_d.wr  = !s_we;
                    end
                end
                ST_ACTIVE: begin
                    if (!cnt_zero) d_d.cnt = d_q.cnt - CNT_W'(1);
                    if (d_q.wr && (we_rise || ce_rise)) begin
                        if (cnt_zero) wr_en = 1'b1;
                        else          d_d.viol = 1'b1;
                        d_d.wr = 1'b0;
                    end
                    if (ce_rise) begin
                        d_d.st  = ST_PRECH;
                        d_d.cnt = C_PC;
                        d_d.wr  = 1'b0;
                    end else if (!d_q.wr && we_fall) begin
                        d_d.wr = 1'b1;
                        if (cnt_zero) d_d.cnt = C_PAGE;
                    end else if (!d_q.wr && (row_in != d_q.row)) begin
                        d_d.st  = ST_ROWPC;
                        d_d.cnt = C_PC;
                    end else if (col_in != d_q.col) begin
                        d_d.col = col_in;
                        d_d.cnt = C_PAGE;
                    end
                end
                ST_ROWPC: begin
                    if (ce_rise) begin
                        d_d.st  = ST_PRECH;
                        d_d.cnt = C_PC;
                    end else if (cnt_zero) begin
                        d_d.st  = ST_ACTIVE;
                        d_d.row = row_in;
                        d_d.col = col_in;
                        d_d.cnt = C_ACC;
                        d_d.wr  = !s_we;
                    end else begin
                        d_d.cnt = d_q.cnt - CNT_W'(1);
                    end
                end
                ST_PRECH, ST_WAKE: begin
                    if (cnt_zero) d_d.st  = ST_IDLE;
                    else          d_d.cnt = d_q.cnt - CNT_W'(1);
                end
                ST_SLEEP: begin
                    d_d.st  = ST_WAKE;
                    d_d.cnt = C_ZZ;
                end
                default: d_d.st = ST_IDLE;
            endcase
        end

        data_ok   = (d_q.st == ST_ACTIVE) && cnt_zero && !d_q.wr
                    && s_sleep && !s_oe && s_we;
        d_d.oe[1] = data_ok && !s_ub;
        d_d.oe[0] = data_ok && !s_lb;
        d_d.dout  = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q      <= '0;
            d_q.st   <= ST_IDLE;
            d_q.p_ce <= 1'b1;
            d_q.p_we <= 1'b1;
        end else begin
            d_q <= d_d;
        end
    end

    assign mem_addr = {d_q.row, d_q.col};
    assign wdata    = s_dq;
    assign wbe      = {!s_ub, !s_lb};
    assign dq_out   = d_q.dout;
    assign dq_oe    = d_q.oe;
    assign viol     = d_q.viol;
    assign state    = d_q.st;
endmodule

// File: rtl/nvm_page_mem.sv
module nvm_page_mem
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int T_ACC  = 8,
    parameter int T_PAGE = 3,
    parameter int T_PC   = 4,
    parameter int T_ZZ   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              sleep_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              viol
);
    logic              s_ce, s_we, s_oe, s_ub, s_lb, s_sleep;
    logic [ADDR_W-1:0] s_addr;
    logic [DQ_W-1:0]   s_dq, rdata, wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic              wr_en;
    logic [LANES-1:0]  wbe;
    nvm_state_e        state;

    nvm_sync #(.W(6), .RST_VAL(6'h3F)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({ce_n, we_n, oe_n, ub_n, lb_n, sleep_n}),
        .q({s_ce, s_we, s_oe, s_ub, s_lb, s_sleep})
    );

    nvm_sync #(.W(ADDR_W + DQ_W), .RST_VAL('0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n),
        .d({addr, dq_in}),
        .q({s_addr, s_dq})
    );

    nvm_ctrl #(
        .ADDR_W(ADDR_W), .T_ACC(T_ACC), .T_PAGE(T_PAGE),
        .T_PC(T_PC), .T_ZZ(T_ZZ)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .s_ce(s_ce), .s_we(s_we), .s_oe(s_oe), .s_ub(s_ub), .s_lb(s_lb),
        .s_sleep(s_sleep), .s_addr(s_addr), .s_dq(s_dq), .rdata(rdata),
        .mem_addr(mem_addr), .wr_en(wr_en), .wdata(wdata), .wbe(wbe),
        .dq_out(dq_out), .dq_oe(dq_oe), .viol(viol), .state(state)
    );

    nvm_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .wr_en(wr_en), .waddr(mem_addr), .wdata(wdata),
        .wbe(wbe), .raddr(mem_addr), .rdata(rdata)
    );
endmodule

// File: rtl/nvm_page_mem_chk.sv
module nvm_page_mem_chk
    import nvm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       s_ce,
    input logic       s_we,
    input logic       s_oe,
    input logic       s_ub,
    input logic       s_lb,
    input logic       s_sleep,
    input logic       wr_en,
    input logic [1:0] dq_oe,
    input logic       viol,
    input nvm_state_e state
);
    // R5: each lane drives only if the previous cycle allowed it
    p_upper_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[1] |-> $past(s_sleep && !s_oe && s_we && !s_ub));
    p_lower_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[0] |-> $past(s_sleep && !s_oe && s_we && !s_lb));
    // R7: commits happen on a rising strobe only
    p_commit_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((s_we && !$past(s_we)) || (s_ce && !$past(s_ce))));
    // R10: a flagged violation was not a commit
    p_viol_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> !$past(wr_en));
    // R11: sleep blocks writes and releases the bus
    p_sleep_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !s_sleep |-> !wr_en);
    p_sleep_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !s_sleep |=> (dq_oe == 2'b00));
    // R6: precharge never jumps straight into an access and never drives
    p_prech_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRECH) |=> (state != ST_ACTIVE));
    p_prech_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRECH) |=> (dq_oe == 2'b00));
endmodule

bind nvm_page_mem nvm_page_mem_chk u_chk (
    .clk(clk), .rst_n(rst_n), .s_ce(s_ce), .s_we(s_we), .s_oe(s_oe),
    .s_ub(s_ub), .s_lb(s_lb), .s_sleep(s_sleep), .wr_en(wr_en),
    .dq_oe(dq_oe), .viol(viol), .state(state)
);

// File: tb/nvm_page_mem_tb.sv
module nvm_page_mem_tb;
    localparam int CLK_P = 10;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic          ub_n = 1'b0, lb_n = 1'b0, sleep_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;
    logic          viol;

    int tests = 0;
    int fails = 0;
    int viol_cnt = 0;

    typedef struct {
        logic [1:0]  oe;
        logic [15:0] d;
        string       tag;
    } exp_t;
    exp_t sb[$];
    event smp;

    always #(CLK_P/2) clk = ~clk;

    nvm_page_mem #(.ADDR_W(AW), .T_ACC(8), .T_PAGE(3), .T_PC(4), .T_ZZ(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .sleep_n(sleep_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .viol(viol)
    );

    always @(posedge clk) if (rst_n && viol) viol_cnt++;

    // monitor: pops expectations and compares with the bus
    initial begin
        forever begin
            @(smp);
            while (sb.size() > 0) begin
                exp_t e;
                logic [15:0] m;
                e = sb.pop_front();
                m = {{8{e.oe[1]}}, {8{e.oe[0]}}};
                tests++;
                if (dq_oe !== e.oe || (dq_out & m) !== (e.d & m)) begin
                    fails++;
                    $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                             e.tag, dq_oe, dq_out & m, e.oe, e.d & m);
                end
            end
        end
    end

    task automatic expect_bus(input logic [1:0] oe, input logic [15:0] d, input string tag);
        exp_t e;
        e.oe = oe; e.d = d; e.tag = tag;
        sb.push_back(e);
        -> smp;
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic close_cycle();
        ce_n = 1'b1; we_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
        wait_n(10);
    endtask

    task automatic wr_we(input logic [AW-1:0] a, input logic [15:0] d,
                         input logic u, input logic l);
        addr = a; dq_in = d; ce_n = 1'b0;
        wait_n(14);
        ub_n = u; lb_n = l; we_n = 1'b0;
        wait_n(6);
        we_n = 1'b1;
        wait_n(6);
        close_cycle();
    endtask

    task automatic wr_ce(input logic [AW-1:0] a, input logic [15:0] d);
        addr = a; dq_in = d; we_n = 1'b0;
        wait_n(1);
        ce_n = 1'b0;
        wait_n(6);
        expect_bus(2'b00, 16'h0, "R7 no drive in write cycle");
        wait_n(8);
        ce_n = 1'b1;
        wait_n(8);
        we_n = 1'b1;
        wait_n(4);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [15:0] d, input string tag);
        addr = a; ce_n = 1'b0;
        wait_n(5);
        expect_bus(2'b00, 16'h0, "R2 not driven before access");
        wait_n(9);
        expect_bus(2'b11, d, tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);
        expect_bus(2'b00, 16'h0, "R12 reset no drive");
        chk(viol === 1'b0, "R12 reset viol low", int'(viol), 0);

        // R7 write-enable controlled writes into one row and another row
        wr_we(10'h004, 16'h1234, 1'b0, 1'b0);
        wr_we(10'h005, 16'h5678, 1'b0, 1'b0);
        wr_we(10'h006, 16'h9ABC, 1'b0, 1'b0);
        wr_we(10'h007, 16'hDEF0, 1'b0, 1'b0);
        wr_we(10'h010, 16'h1111, 1'b0, 1'b0);
        chk(viol_cnt == 0, "R7 clean writes no viol", viol_cnt, 0);

        // R1 R2 read, R3 page, R4 row change
        rd(10'h004, 16'h1234, "R1 R2 read word");
        addr = 10'h005; wait_n(8);
        expect_bus(2'b11, 16'h5678, "R3 page read col1");
        addr = 10'h007; wait_n(8);
        expect_bus(2'b11, 16'hDEF0, "R3 page read col3");
        addr = 10'h010; wait_n(8);
        expect_bus(2'b00, 16'h0, "R4 row change still precharging");
        wait_n(12);
        expect_bus(2'b11, 16'h1111, "R4 new row word");

        // R5 lane gating
        oe_n = 1'b1; wait_n(4);
        expect_bus(2'b00, 16'h0, "R5 oe high no drive");
        oe_n = 1'b0; ub_n = 1'b1; wait_n(4);
        expect_bus(2'b01, 16'h1111, "R5 lower lane only");
        ub_n = 1'b0; lb_n = 1'b1; wait_n(4);
        expect_bus(2'b10, 16'h1111, "R5 upper lane only");
        close_cycle();

        // R9 byte mask: lower lane only
        wr_we(10'h004, 16'hAAAA, 1'b1, 1'b0);
        rd(10'h004, 16'h12AA, "R9 masked upper kept");
        close_cycle();

        // R7 chip-enable controlled write
        wr_ce(10'h020, 16'h4242);
        rd(10'h020, 16'h4242, "R7 ce-controlled commit");
        close_cycle();

        // R8 page writes in one open row
        addr = 10'h030; ce_n = 1'b0; wait_n(14);
        for (int c = 0; c < 4; c++) begin
            addr = 10'h030 + AW'(c);
            dq_in = 16'hC000 + 16'(c * 16'h0101);
            wait_n(6);
            we_n = 1'b0; wait_n(6);
            we_n = 1'b1; wait_n(6);
        end
        close_cycle();
        rd(10'h030, 16'hC000, "R8 page write col0");
        for (int c = 1; c < 4; c++) begin
            addr = 10'h030 + AW'(c); wait_n(8);
            expect_bus(2'b11, 16'hC000 + 16'(c * 16'h0101), "R8 page write col");
        end
        close_cycle();

        // R10 early write end
        wr_we(10'h040, 16'h0BAD, 1'b0, 1'b0);
        begin
            int v0;
            v0 = viol_cnt;
            addr = 10'h040; dq_in = 16'h7777; ce_n = 1'b0;
            wait_n(2);
            we_n = 1'b0; wait_n(1);
            we_n = 1'b1; wait_n(4);
            chk(viol_cnt == v0 + 1, "R10 violation flagged", viol_cnt, v0 + 1);
        end
        close_cycle();
        rd(10'h040, 16'h0BAD, "R10 no commit on violation");
        close_cycle();

        // R6 refusal during precharge
        rd(10'h006, 16'h9ABC, "R6 read before precharge");
        ce_n = 1'b1; wait_n(1);
        ce_n = 1'b0; wait_n(16);
        expect_bus(2'b00, 16'h0, "R6 fall in precharge refused");
        close_cycle();

        // R11 sleep and wake
        rd(10'h005, 16'h5678, "R11 read before sleep");
        sleep_n = 1'b0; wait_n(4);
        expect_bus(2'b00, 16'h0, "R11 sleep releases bus");
        ce_n = 1'b1; wait_n(3);
        ce_n = 1'b0; wait_n(6);
        expect_bus(2'b00, 16'h0, "R11 inputs ignored in sleep");
        sleep_n = 1'b1; ce_n = 1'b1; wait_n(2);
        ce_n = 1'b0; wait_n(14);
        expect_bus(2'b00, 16'h0, "R11 refused during wake");
        ce_n = 1'b1; wait_n(30);
        rd(10'h005, 16'h5678, "R11 access after wake");
        close_cycle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule